// File: doc/BRIEF.md
# Replicated Interrupt Mask Block

This block sits between a shared 64-bit interrupt request vector and several level-high interrupt lines that feed a primary interrupt controller. The request vector comes from an edge/level conditioning stage, which lies outside this block. The block holds one mask window per output line. There are three by default, at byte addresses 0x000, 0x100 and 0x300. Each window has its own 64-bit enable register and its own 64-bit software-request register. The window ORs the shared request vector with its soft requests, which gives the raw status. It then ANDs the raw status with its enable bits, which gives the masked status. Its output line is high while any masked bit is set.

Software sees each window through 32-bit registers, split into a low half for inputs 0 to 31 and a high half for inputs 32 to 63. Within the low half the offsets are as follows:

- 0x00: masked status
- 0x04: raw status
- 0x08: enable-set
- 0x0c: enable-clear
- 0x10: soft-set
- 0x14: soft-clear

The high-half copy of each register sits 0x18 above its low-half twin. A service routine reads masked status and handles set bits starting from bit 0 of the low half, then the high half. The set/clear pairs let several agents change separate bits without a read-modify-write.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: After a synchronous reset, every enable bit and soft-request bit is zero in all windows. All masked status words read 0 and every output line is low.
- R2: Raw status equals the shared request ORed with the window's soft-request bits. The low half is at window offset 0x04 and the high half at 0x1c.
- R3: Masked status equals raw status ANDed with the window's enable bits. The low half is at offset 0x00 and the high half at 0x18.
- R4: A write to enable-set (0x08 low, 0x20 high) sets the enable bits written as 1. A write to enable-clear (0x0c low, 0x24 high) clears them. Bits written as 0 keep their value.
- R5: A write to soft-set (0x10 low, 0x28 high) sets the soft bits written as 1. A write to soft-clear (0x14 low, 0x2c high) clears them. Bits written as 0 keep their value.
- R6: Output line k (irq_o[k]) is a registered copy of "any masked bit of window k is set". It changes one clock after the register or request change that causes it.
- R7: Window k drives line k, with window 0 at 0x000, window 1 at 0x100 and window 2 at 0x300. A write to one window leaves the other windows' enables, soft bits and lines unchanged. All windows observe the same request vector.
- R8: Unmapped accesses are ignored on write and read as 0. These are addresses in the 0x200 page, window offsets of 0x30 and above, and offsets that are not 4-byte aligned.
- R9: Writes to the status offsets change nothing. The four set/clear offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 64 | Conditioned request vector shared by all windows |
| addr_i | input | 10 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, applied at the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational, no side effects) |
| irq_o | output | 3 | Level-high interrupt line per window |

## Verification
The bench walks set and clear writes across bit 0, bit 31 and the high half. A design that treated a set write as a plain store would drop previously enabled bits, and the masked-status readback would show it. Soft bits are injected into one window while the others are watched. A design that shared the soft register between windows, or drove the wrong line, would show extra raw bits or an extra line in a neighbouring window. Writes go to the unused 0x200 page, to offsets past the high half, to unaligned offsets and to the read-only status offsets. Any decode that aliased them would turn enables on and light a line. A mid-test reset and a request that drops while enabled check that the line falls one cycle later and does not hold state.

// File: rtl/irqm_pkg.sv
`timescale 1ns/1ps
// Package: shared register slot encoding and layout constants for the
// interrupt mask windows. Assumes 32-bit word-aligned register access.
package irqm_pkg;

    // Register slot inside one half, in address order (offset = slot * 4)
    typedef enum logic [2:0] {
        SLOT_MSK = 3'd0,
        SLOT_RAW = 3'd1,
        SLOT_ENS = 3'd2,
        SLOT_ENC = 3'd3,
        SLOT_SFS = 3'd4,
        SLOT_SFC = 3'd5
    } slot_e;

    localparam int WORD_BYTES = 4;
    localparam int SLOT_COUNT = 6;
    // Distance between a low-half register and its high-half twin
    localparam int HALF_BYTES = SLOT_COUNT * WORD_BYTES;

endpackage

// File: rtl/irqm_decode.sv
`timescale 1ns/1ps
// Module: address decoder. Splits a byte address into a window hit vector
// (one bit per output line), the half index and the register slot.
// Assumes: window bases differ only above WIN_SPAN_W; purely combinational.
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int                          ADDR_W     = 10,
    parameter int                          WIN_SPAN_W = 8,
    parameter int                          NUM_LINES  = 3,
    parameter int                          NUM_HALVES = 2,
    parameter logic [NUM_LINES*ADDR_W-1:0] WIN_BASES  = {10'h300, 10'h100, 10'h000},
    localparam int                         HIDX_W     = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_LINES-1:0] win_hit_o,
    output logic                 off_ok_o,
    output logic [HIDX_W-1:0]    half_o,
    output slot_e                slot_o
);

    localparam int PAGE_W = ADDR_W - WIN_SPAN_W;

    logic [PAGE_W-1:0]     page;
    logic [WIN_SPAN_W-1:0] offset;

    assign page   = addr_i[ADDR_W-1:WIN_SPAN_W];
    assign offset = addr_i[WIN_SPAN_W-1:0];

    // One comparator per window base
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE_K = WIN_BASES[k*ADDR_W +: ADDR_W];
        assign win_hit_o[k] = (page == BASE_K[ADDR_W-1:WIN_SPAN_W]);
    end

    // Offset to (half, slot) split with range and alignment test
    always_comb begin
        int off_int;
        int hq;
        int rem;
        off_int  = int'({{(32-WIN_SPAN_W){1'b0}}, offset});
        hq       = off_int / HALF_BYTES;
        rem      = off_int - hq * HALF_BYTES;
        off_ok_o = (hq < NUM_HALVES) && ((rem % WORD_BYTES) == 0);
        half_o   = HIDX_W'(hq);
        slot_o   = slot_e'(3'(rem / WORD_BYTES));
    end

endmodule

// File: rtl/irqm_half.sv
`timescale 1ns/1ps
// Module: one 32-bit half of a mask window. Holds the enable and soft
// request bits and forms raw and masked status.
// Assumes: at most one strobe per cycle (guaranteed by the decoder).
module irqm_half #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] req_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              sf_set_i,
    input  logic              sf_clr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] raw_o,
    output logic [DATA_W-1:0] masked_o,
    output logic              soft_any_o
);

    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] soft_q;

    // Enable bits: set/clear only the bits written as 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_set_i) begin
            en_q <= en_q | wdata_i;
        end else if (en_clr_i) begin
            en_q <= en_q & ~wdata_i;
        end
    end

    // Soft request bits: same bitwise set/clear rule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= '0;
        end else if (sf_set_i) begin
            soft_q <= soft_q | wdata_i;
        end else if (sf_clr_i) begin
            soft_q <= soft_q & ~wdata_i;
        end
    end

    assign raw_o      = req_i | soft_q;
    assign masked_o   = raw_o & en_q;
    assign soft_any_o = |soft_q;

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_set_i && !en_clr_i) |=> $stable(en_q));

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

    // R5
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sf_set_i && !sf_clr_i) |=> $stable(soft_q));

    // R5
    soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sf_clr_i |=> ((soft_q & $past(wdata_i)) == '0));

endmodule

// File: rtl/irqm_line.sv
`timescale 1ns/1ps
// Module: one complete mask window driving one output line. Turns the
// decoded access into per-half strobes and read data, and registers the
// line. Assumes sel_i already includes the window hit and offset check.
module irqm_line
    import irqm_pkg::*;
#(
    parameter int  DATA_W     = 32,
    parameter int  NUM_HALVES = 2,
    localparam int HIDX_W     = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1,
    localparam int REQ_W      = NUM_HALVES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REQ_W-1:0]  req_i,
    input  logic              sel_i,
    input  logic              wr_en_i,
    input  logic [HIDX_W-1:0] half_i,
    input  slot_e             slot_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic [NUM_HALVES-1:0][DATA_W-1:0] raw_w;
    logic [NUM_HALVES-1:0][DATA_W-1:0] masked_w;
    logic [NUM_HALVES-1:0]             soft_any_w;
    logic [NUM_HALVES-1:0]             pend_w;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic hwr;
        assign hwr = sel_i && wr_en_i && (half_i == HIDX_W'(h));

        irqm_half #(.DATA_W(DATA_W)) u_half (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (req_i[h*DATA_W +: DATA_W]),
            .en_set_i   (hwr && (slot_i == SLOT_ENS)),
            .en_clr_i   (hwr && (slot_i == SLOT_ENC)),
            .sf_set_i   (hwr && (slot_i == SLOT_SFS)),
            .sf_clr_i   (hwr && (slot_i == SLOT_SFC)),
            .wdata_i    (wdata_i),
            .raw_o      (raw_w[h]),
            .masked_o   (masked_w[h]),
            .soft_any_o (soft_any_w[h])
        );

        assign pend_w[h] = |masked_w[h];
    end

    // Read mux: only the two status slots return data
    always_comb begin
        rdata_o = '0;
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (sel_i && (half_i == HIDX_W'(h))) begin
                case (slot_i)
                    SLOT_MSK: rdata_o = masked_w[h];
                    SLOT_RAW: rdata_o = raw_w[h];
                    default:  rdata_o = '0;
                endcase
            end
        end
    end

    // Output line register: glitch-free level to the primary controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |pend_w;
        end
    end

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(req_i) == '0) && ($past(soft_any_w) == '0)) |-> !irq_o);

endmodule

// File: rtl/irq_fanout_ctrl.sv
`timescale 1ns/1ps
// Module: top of the replicated interrupt mask block. One decoder and
// NUM_LINES mask windows over a shared request vector; read data is the
// OR of the per-window read muxes (at most one window is selected).
// Assumes: NUM_IN is a multiple of DATA_W; window bases are distinct pages.
module irq_fanout_ctrl
    import irqm_pkg::*;
#(
    parameter int                          NUM_IN     = 64,
    parameter int                          DATA_W     = 32,
    parameter int                          ADDR_W     = 10,
    parameter int                          WIN_SPAN_W = 8,
    parameter int                          NUM_LINES  = 3,
    parameter logic [NUM_LINES*ADDR_W-1:0] WIN_BASES  = {10'h300, 10'h100, 10'h000}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IN-1:0]    req_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);

    localparam int NUM_HALVES = NUM_IN / DATA_W;
    localparam int HIDX_W     = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;

    logic [NUM_LINES-1:0]             win_hit;
    logic                             off_ok;
    logic [HIDX_W-1:0]                half_sel;
    slot_e                            slot_sel;
    logic [NUM_LINES-1:0]             line_sel;
    logic [NUM_LINES-1:0][DATA_W-1:0] line_rdata;

    irqm_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_SPAN_W (WIN_SPAN_W),
        .NUM_LINES  (NUM_LINES),
        .NUM_HALVES (NUM_HALVES),
        .WIN_BASES  (WIN_BASES)
    ) u_decode (
        .addr_i    (addr_i),
        .win_hit_o (win_hit),
        .off_ok_o  (off_ok),
        .half_o    (half_sel),
        .slot_o    (slot_sel)
    );

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        assign line_sel[k] = win_hit[k] && off_ok;

        irqm_line #(
            .DATA_W     (DATA_W),
            .NUM_HALVES (NUM_HALVES)
        ) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_i),
            .sel_i   (line_sel[k]),
            .wr_en_i (wr_en_i),
            .half_i  (half_sel),
            .slot_i  (slot_sel),
            .wdata_i (wdata_i),
            .rdata_o (line_rdata[k]),
            .irq_o   (irq_o[k])
        );
    end

    // Combine per-window read data
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            rdata_o = rdata_o | line_rdata[k];
        end
    end

    // R7
    win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_sel));

    // R8
    stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sel == '0) |-> (rdata_o == '0));

endmodule

// File: tb/test_irq_fanout_ctrl.sv
`timescale 1ns/1ps
module test_irq_fanout_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] req = '0;
    logic [9:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_fanout_ctrl i_irq_fanout_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    localparam logic [9:0] W0 = 10'h000;
    localparam logic [9:0] W1 = 10'h100;
    localparam logic [9:0] W2 = 10'h300;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    // Monitor: pops one expected item per sample event and compares
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            @(sample_ev);
            it  = sb.pop_front();
            act = it.is_irq ? {29'd0, irq} : rdata;
            vectors++;
            if (act !== it.exp) begin
                miscompares++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        it.is_irq = 1'b0;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        #1;
        ->sample_ev;
        #1;
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1;
        it.exp = {29'd0, e};
        it.tag = tag;
        sb.push_back(it);
        #1;
        ->sample_ev;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(3'b000, "R1 lines low after reset");
        chk_rd(W0 + 10'h00, 32'h0, "R1 masked lo zero");
        chk_rd(W2 + 10'h18, 32'h0, "R1 masked hi zero");
        req = {32'hF0F0_1234, 32'h8000_0001};
        chk_rd(W0 + 10'h04, 32'h8000_0001, "R2 raw lo follows request");
        chk_rd(W0 + 10'h1C, 32'hF0F0_1234, "R2 raw hi follows request");
        chk_rd(W0 + 10'h00, 32'h0, "R1 masked stays zero with enables clear");
        chk_irq(3'b000, "R1 lines stay low");

        // R4 / R3 / R6 enable set/clear on window 0
        wr(W0 + 10'h08, 32'h0000_0001);
        chk_rd(W0 + 10'h00, 32'h0000_0001, "R3 masked lo after enable bit0");
        chk_irq(3'b001, "R6 line 0 high");
        chk_rd(W1 + 10'h00, 32'h0, "R7 window 1 untouched");
        wr(W0 + 10'h08, 32'h8000_0000);
        chk_rd(W0 + 10'h00, 32'h8000_0001, "R4 set keeps earlier bits");
        wr(W0 + 10'h0C, 32'h0000_0001);
        chk_rd(W0 + 10'h00, 32'h8000_0000, "R4 clear only bit0");
        wr(W0 + 10'h0C, 32'h8000_0000);
        chk_rd(W0 + 10'h00, 32'h0, "R4 clear bit31");
        chk_irq(3'b000, "R6 line 0 falls");

        // High half on window 2
        wr(W2 + 10'h20, 32'h0000_1000);
        chk_rd(W2 + 10'h18, 32'h0000_1000, "R3 masked hi window 2");
        chk_irq(3'b100, "R7 only line 2 high");
        chk_rd(W0 + 10'h18, 32'h0, "R7 window 0 hi untouched");

        // R5 soft requests on window 1
        wr(W1 + 10'h10, 32'h0000_0F00);
        chk_rd(W1 + 10'h04, 32'h8000_0F01, "R5 soft set raw lo");
        chk_rd(W0 + 10'h04, 32'h8000_0001, "R7 soft private to window 1");
        chk_irq(3'b100, "R3 soft masked by enable");
        wr(W1 + 10'h08, 32'h0000_0100);
        chk_rd(W1 + 10'h00, 32'h0000_0100, "R3 soft bit enabled");
        chk_irq(3'b110, "R6 line 1 high from soft");
        wr(W1 + 10'h14, 32'h0000_0E00);
        chk_rd(W1 + 10'h04, 32'h8000_0101, "R5 soft clear only ones");
        wr(W1 + 10'h14, 32'h0000_0100);
        chk_rd(W1 + 10'h00, 32'h0, "R5 soft cleared masked zero");
        chk_irq(3'b100, "R6 line 1 falls");
        wr(W1 + 10'h28, 32'h0000_0002);
        chk_rd(W1 + 10'h1C, 32'hF0F0_1236, "R5 soft set raw hi");

        // R8 unmapped accesses
        wr(10'h208, 32'hFFFF_FFFF);
        chk_rd(W0 + 10'h00, 32'h0, "R8 page 0x200 write ignored");
        chk_rd(10'h204, 32'h0, "R8 page 0x200 reads zero");
        wr(W0 + 10'h30, 32'hFFFF_FFFF);
        chk_rd(W0 + 10'h30, 32'h0, "R8 offset 0x30 reads zero");
        wr(W0 + 10'h09, 32'hFFFF_FFFF);
        chk_rd(W0 + 10'h00, 32'h0, "R8 unaligned write ignored");
        chk_rd(W0 + 10'h05, 32'h0, "R8 unaligned read zero");
        chk_irq(3'b100, "R8 lines unchanged");

        // R9 read-only status, write-only commands
        wr(W2 + 10'h18, 32'h0000_0000);
        chk_rd(W2 + 10'h18, 32'h0000_1000, "R9 status write no effect");
        wr(W2 + 10'h1C, 32'hFFFF_FFFF);
        chk_rd(W2 + 10'h1C, 32'hF0F0_1234, "R9 raw write no effect");
        chk_rd(W2 + 10'h20, 32'h0, "R9 enable-set reads zero");
        chk_rd(W1 + 10'h14, 32'h0, "R9 soft-clear reads zero");

        // Request drop, shared vector
        @(negedge clk);
        req = {32'hF0F0_0234, 32'h8000_0001};
        chk_irq(3'b000, "R6 line 2 falls one cycle after request drop");
        chk_rd(W1 + 10'h1C, 32'hF0F0_0236, "R7 shared request in window 1");

        // Mid-run reset
        wr(W0 + 10'h08, 32'hFFFF_FFFF);
        chk_irq(3'b001, "R6 line 0 high before reset");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk_rd(W0 + 10'h00, 32'h0, "R1 enables cleared by reset");
        chk_rd(W1 + 10'h1C, 32'hF0F0_0234, "R1 soft cleared by reset");
        chk_irq(3'b000, "R1 lines low after reset");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule